// File: doc/BRIEF.md
# Transport Stream Section Filter

This block sits on a byte-wide MPEG-2 transport stream and picks out the packets that carry wanted sections. Each packet begins with a start strobe on its first byte. The block reads the 13-bit PID from the header and looks it up in a table of 32 programmable entries. Every enabled entry names its own substream through its table index. For packets that hit an entry, the block forwards the payload bytes together with that index, so a storage engine downstream can write them.

Each PID entry also points to a run of filter conditions in a shared pool. A condition is a match value plus a mask of the same length, and only the bits set in the mask take part in the compare. The pool holds 80 slots of 4 bytes. In wide mode, two adjacent slots pair up into one 8-byte condition, which gives 40 conditions. PIDs may claim runs of different lengths. The conditions are tried one per clock while the packet keeps streaming. With the packet's last payload byte the block raises a match pulse if any condition in the run accepted the section header bytes. The downstream engine then commits the packet or discards it.

Top module: `ts_section_filter`

## Requirements
- R1: After synchronous reset, out_valid and out_match are low. Every PID entry is disabled, every pool slot is zero and the 4-byte mode is selected.
- R2: A packet begins on an accepted byte with in_start high whose value is 0x47, and it spans 188 accepted bytes (index 0 to 187). If the start byte holds any other value, the bytes up to the next start produce no output.
- R3: The 13-bit PID is formed from bits 4:0 of byte 1 (high part) and all of byte 2. It selects the lowest-indexed enabled table entry with the same PID. If no enabled entry matches, the packet produces no output. A PID entry is written with cfg_sel=0 at cfg_addr[4:0], with the data layout enable=[31], count=[26:20], base=[19:13], PID=[12:0].
- R4: A packet whose byte 1 bit 7 (transport error) is set produces no output.
- R5: For an accepted packet, bytes 4 to 187 appear on out_data with out_valid high, one clock after each is accepted. out_idx carries the hit entry index while out_valid is high.
- R6: In 4-byte mode (mode bit 0 = 0, written with cfg_sel=3), condition c uses pool slot c. Packet bytes 5..8, with byte 5 in bits 31:24, match when their XOR with the slot value, ANDed with the slot mask, is zero. Slot values are written with cfg_sel=1 and masks with cfg_sel=2, at cfg_addr.
- R7: In 8-byte mode (mode bit 0 = 1), condition c uses slot 2c for bytes 5..8 and slot 2c+1 for bytes 9..12. Both halves must match. A condition whose slots lie outside the pool never matches.
- R8: A packet passes if any of the count conditions, starting at base, matches. An entry with count zero passes every packet.
- R9: out_match is high for exactly the cycle that carries byte 187 of a passing packet, and it is low on every other cycle.
- R10: Cycles with in_valid low are not counted as bytes and do not disturb the packet in progress.
- R11: A start strobe in the middle of a packet abandons that packet and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 PID entry, 1 slot value, 2 slot mask, 3 mode |
| cfg_addr | input | 7 | Entry or slot index |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Input byte valid |
| in_start | input | 1 | First byte of a packet |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_match | output | 1 | Packet passed the section conditions (with its last byte) |
| out_idx | output | 5 | Index of the hit PID entry |

## Verification
A wrong PID entry or a wrong header capture shows up on the first payload byte, five cycles after the packet starts: either as a spurious or missing out_valid, or as a wrong out_idx. A wrong sequencer pointer, a wrong remaining count or a mis-paired wide slot stays hidden until byte 187, where out_match is wrong. For that reason the bench puts each condition case in its own packet, with windows that differ from the programmed values by a single masked bit. A window shift error changes which bytes are compared, so it appears in the same way at the end of the packet.

// File: rtl/ts_sf_pkg.sv
`timescale 1ns/1ps
package ts_sf_pkg;
    localparam int NUM_PID   = 32;
    localparam int NUM_SLOT  = 80;
    localparam int PKT_LEN   = 188;
    localparam int PID_W     = 13;
    localparam int WIN_FIRST = 5;
    localparam int WIN_BYTES = 8;
    localparam int PAY_FIRST = 4;

    localparam int IDX_W    = $clog2(NUM_PID);
    localparam int SLOT_W   = $clog2(NUM_SLOT);
    localparam int CNT_W    = $clog2(PKT_LEN);
    localparam int WIN_W    = WIN_BYTES * 8;
    localparam int HALF_W   = WIN_W / 2;
    localparam int WIN_LAST = WIN_FIRST + WIN_BYTES - 1;

    localparam logic [7:0] SYNC_BYTE = 8'h47;

    typedef enum logic [1:0] {
        SEL_PID  = 2'd0,
        SEL_VAL  = 2'd1,
        SEL_MSK  = 2'd2,
        SEL_MODE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] num;
        logic [SLOT_W-1:0] base;
        logic [PID_W-1:0]  pid;
    } pid_ent_t;

    function automatic pid_ent_t unpack_ent(input logic [31:0] w);
        pid_ent_t e;
        e.en   = w[31];
        e.num  = w[20 +: SLOT_W];
        e.base = w[13 +: SLOT_W];
        e.pid  = w[PID_W-1:0];
        return e;
    endfunction

    function automatic logic masked_eq(input logic [HALF_W-1:0] d,
                                       input logic [HALF_W-1:0] v,
                                       input logic [HALF_W-1:0] m);
        return ((d ^ v) & m) == '0;
    endfunction
endpackage

// File: rtl/ts_sf_pid_table.sv
`timescale 1ns/1ps
module ts_sf_pid_table
    import ts_sf_pkg::*;
#(
    parameter int N = NUM_PID,
    localparam int IW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IW-1:0]    waddr,
    input  pid_ent_t         wdata,
    input  logic [PID_W-1:0] look_pid,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output pid_ent_t         hit_ent
);
    pid_ent_t       tbl [N];
    logic [N-1:0]   match_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) tbl[i] <= '0;
        end else if (we) begin
            tbl[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_vec[g] = tbl[g].en && (tbl[g].pid == look_pid);
    end

    // lowest index wins: scan downward so the last assignment is the lowest hit
    always_comb begin
        hit     = |match_vec;
        hit_idx = '0;
        hit_ent = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_idx = IW'(i);
                hit_ent = tbl[i];
            end
        end
    end
endmodule

// File: rtl/ts_sf_cond_pool.sv
`timescale 1ns/1ps
module ts_sf_cond_pool
    import ts_sf_pkg::*;
#(
    parameter int NS = NUM_SLOT,
    localparam int SW = $clog2(NS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_val,
    input  logic              we_msk,
    input  logic [SW-1:0]     waddr,
    input  logic [HALF_W-1:0] wdata,
    input  logic              wide,
    input  logic [SW-1:0]     cidx,
    input  logic [WIN_W-1:0]  window,
    output logic              hit
);
    localparam logic [SW:0] NSV = NS[SW:0];

    logic [HALF_W-1:0] val [NS];
    logic [HALF_W-1:0] msk [NS];
    logic [SW:0]       lo, hi;
    logic              lo_ok, hi_ok, lo_hit, hi_hit, wr_ok;

    assign wr_ok = {1'b0, waddr} < NSV;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) begin
                val[i] <= '0;
                msk[i] <= '0;
            end
        end else if (wr_ok) begin
            if (we_val) val[waddr] <= wdata;
            if (we_msk) msk[waddr] <= wdata;
        end
    end

    assign lo    = wide ? {cidx, 1'b0} : {1'b0, cidx};
    assign hi    = lo | {{SW{1'b0}}, 1'b1};
    assign lo_ok = lo < NSV;
    assign hi_ok = hi < NSV;

    assign lo_hit = lo_ok && masked_eq(window[WIN_W-1:HALF_W],
                                       val[lo[SW-1:0]], msk[lo[SW-1:0]]);
    assign hi_hit = hi_ok && masked_eq(window[HALF_W-1:0],
                                       val[hi[SW-1:0]], msk[hi[SW-1:0]]);
    assign hit    = lo_hit && (!wide || hi_hit);
endmodule

// File: rtl/ts_section_filter.sv
`timescale 1ns/1ps
module ts_section_filter
    import ts_sf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [SLOT_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [7:0]        in_data,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_match,
    output logic [IDX_W-1:0]  out_idx
);
    localparam logic [CNT_W-1:0] B_HDR1  = CNT_W'(1);
    localparam logic [CNT_W-1:0] B_HDR2  = CNT_W'(2);
    localparam logic [CNT_W-1:0] B_PAY   = CNT_W'(PAY_FIRST);
    localparam logic [CNT_W-1:0] B_WIN0  = CNT_W'(WIN_FIRST);
    localparam logic [CNT_W-1:0] B_WIN1  = CNT_W'(WIN_LAST);
    localparam logic [CNT_W-1:0] B_LAST  = CNT_W'(PKT_LEN - 1);

    cfg_sel_e           sel;
    logic               wide;
    logic               in_pkt, tei, pass, busy, result;
    logic [CNT_W-1:0]   cnt;
    logic [PID_W-9:0]   pid_hi;
    logic [IDX_W-1:0]   idx;
    logic [SLOT_W-1:0]  ent_base, ent_num, ptr, remain;
    logic [WIN_W-1:0]   win;
    logic               hit, cond_hit, take, sop;
    logic [IDX_W-1:0]   hit_idx;
    pid_ent_t           hit_ent;

    assign sel  = cfg_sel_e'(cfg_sel);
    assign sop  = in_valid && in_start;
    assign take = in_valid && !in_start && in_pkt;

    ts_sf_pid_table #(.N(NUM_PID)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we && sel == SEL_PID),
        .waddr    (cfg_addr[IDX_W-1:0]),
        .wdata    (unpack_ent(cfg_wdata)),
        .look_pid ({pid_hi, in_data}),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .hit_ent  (hit_ent)
    );

    ts_sf_cond_pool #(.NS(NUM_SLOT)) u_pool (
        .clk    (clk),
        .rst    (rst),
        .we_val (cfg_we && sel == SEL_VAL),
        .we_msk (cfg_we && sel == SEL_MSK),
        .waddr  (cfg_addr),
        .wdata  (cfg_wdata),
        .wide   (wide),
        .cidx   (ptr),
        .window (win),
        .hit    (cond_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) wide <= 1'b0;
        else if (cfg_we && sel == SEL_MODE) wide <= cfg_wdata[0];
    end

    // packet framing and header capture
    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt   <= 1'b0;
            cnt      <= '0;
            tei      <= 1'b0;
            pid_hi   <= '0;
            pass     <= 1'b0;
            idx      <= '0;
            ent_base <= '0;
            ent_num  <= '0;
            win      <= '0;
        end else if (sop) begin
            in_pkt <= (in_data == SYNC_BYTE);
            cnt    <= B_HDR1;
            pass   <= 1'b0;
        end else if (take) begin
            cnt <= cnt + 1'b1;
            if (cnt == B_LAST) in_pkt <= 1'b0;
            if (cnt == B_HDR1) begin
                tei    <= in_data[7];
                pid_hi <= in_data[PID_W-9:0];
            end
            if (cnt == B_HDR2) begin
                pass     <= hit && !tei;
                idx      <= hit_idx;
                ent_base <= hit_ent.base;
                ent_num  <= hit_ent.num;
            end
            if (cnt >= B_WIN0 && cnt <= B_WIN1) win <= {win[WIN_W-9:0], in_data};
        end
    end

    // condition sequencer: one pool condition per clock after the window fills
    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            result <= 1'b0;
            ptr    <= '0;
            remain <= '0;
        end else if (sop) begin
            busy   <= 1'b0;
            result <= 1'b0;
        end else if (take && cnt == B_WIN1) begin
            busy   <= pass && (ent_num != '0);
            result <= (ent_num == '0);
            ptr    <= ent_base;
            remain <= ent_num;
        end else if (busy) begin
            if (cond_hit) begin
                result <= 1'b1;
                busy   <= 1'b0;
            end else begin
                ptr    <= ptr + 1'b1;
                remain <= remain - 1'b1;
                if (remain == SLOT_W'(1)) busy <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_match <= 1'b0;
            out_idx   <= '0;
        end else begin
            out_valid <= take && pass && (cnt >= B_PAY);
            out_data  <= in_data;
            out_match <= take && pass && (cnt == B_LAST) && result;
            out_idx   <= idx;
        end
    end
endmodule

// File: rtl/ts_sf_chk.sv
`timescale 1ns/1ps
module ts_sf_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_match
);
    a_r9_match_with_byte: assert property (@(posedge clk) disable iff (rst)
        out_match |-> out_valid);

    a_r9_match_single: assert property (@(posedge clk) disable iff (rst)
        out_match |=> !out_match);

    a_r10_valid_needs_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    a_r5_data_follows_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data == $past(in_data));
endmodule

bind ts_section_filter ts_sf_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_match (out_match)
);

// File: tb/test_ts_section_filter.sv
`timescale 1ns/1ps
module test_ts_section_filter;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [6:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        in_valid, in_start;
    logic [7:0]  in_data;
    logic        out_valid, out_match;
    logic [7:0]  out_data;
    logic [4:0]  out_idx;

    always #2.5 clk = ~clk;

    ts_section_filter i_ts_section_filter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
        .in_start(in_start), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data), .out_match(out_match), .out_idx(out_idx)
    );

    // behavioural model state
    bit          m_en  [32];
    logic [12:0] m_pid [32];
    int          m_base[32];
    int          m_num [32];
    logic [31:0] m_val [80];
    logic [31:0] m_msk [80];
    bit          m_wide;
    logic [7:0]  pkt [188];

    logic        exp_valid, exp_match;
    logic [7:0]  exp_data;
    logic [4:0]  exp_idx;
    string       req;
    int          n_tests = 0, n_fail = 0;

    task automatic check_outputs();
        n_tests++;
        if (out_valid !== exp_valid || out_match !== exp_match ||
            (exp_valid && (out_data !== exp_data || out_idx !== exp_idx))) begin
            n_fail++;
            $display("FAIL %s: valid/match/data/idx actual=%b/%b/%h/%0d expected=%b/%b/%h/%0d",
                     req, out_valid, out_match, out_data, out_idx,
                     exp_valid, exp_match, exp_data, exp_idx);
        end
    endtask

    task automatic tick_idle();
        @(negedge clk);
        check_outputs();
        cfg_we = 0; in_valid = 0; in_start = 0;
        exp_valid = 0; exp_match = 0;
    endtask

    task automatic drive_byte(input logic [7:0] d, input bit st, input bit ev,
                              input bit em, input logic [4:0] ei);
        @(negedge clk);
        check_outputs();
        cfg_we = 0; in_valid = 1; in_start = st; in_data = d;
        exp_valid = ev; exp_match = em; exp_data = d; exp_idx = ei;
    endtask

    task automatic cfg(input logic [1:0] s, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        check_outputs();
        in_valid = 0; in_start = 0;
        cfg_we = 1; cfg_sel = s; cfg_addr = a; cfg_wdata = d;
        exp_valid = 0; exp_match = 0;
        case (s)
            2'd0: begin
                m_en[a[4:0]]   = d[31];
                m_num[a[4:0]]  = int'(d[26:20]);
                m_base[a[4:0]] = int'(d[19:13]);
                m_pid[a[4:0]]  = d[12:0];
            end
            2'd1: m_val[a] = d;
            2'd2: m_msk[a] = d;
            default: m_wide = d[0];
        endcase
    endtask

    function automatic bit cond_ok(input int c);
        logic [31:0] w0, w1;
        w0 = {pkt[5], pkt[6], pkt[7], pkt[8]};
        w1 = {pkt[9], pkt[10], pkt[11], pkt[12]};
        if (m_wide) begin
            if (2 * c + 1 >= 80) return 0;
            return (((w0 ^ m_val[2*c]) & m_msk[2*c]) == 0) &&
                   (((w1 ^ m_val[2*c+1]) & m_msk[2*c+1]) == 0);
        end
        if (c >= 80) return 0;
        return ((w0 ^ m_val[c]) & m_msk[c]) == 0;
    endfunction

    task automatic build(input logic [12:0] pid, input bit tei,
                         input logic [31:0] w0, input logic [31:0] w1, input int seed);
        for (int j = 0; j < 188; j++) pkt[j] = 8'(j * 7 + seed);
        pkt[0] = 8'h47;
        pkt[1] = {tei, 2'b00, pid[12:8]};
        pkt[2] = pid[7:0];
        pkt[3] = 8'h10;
        {pkt[5], pkt[6], pkt[7], pkt[8]}   = w0;
        {pkt[9], pkt[10], pkt[11], pkt[12]} = w1;
    endtask

    task automatic send(input int nbytes, input bit gaps);
        bit         pass = 0, matched = 0;
        logic [4:0] idx = 0;
        logic [12:0] pid = {pkt[1][4:0], pkt[2]};
        if (pkt[0] == 8'h47 && !pkt[1][7]) begin
            for (int i = 31; i >= 0; i--)
                if (m_en[i] && m_pid[i] == pid) begin pass = 1; idx = 5'(i); end
        end
        if (pass) begin
            if (m_num[idx] == 0) matched = 1;
            for (int k = 0; k < m_num[idx]; k++)
                if (cond_ok(m_base[idx] + k)) matched = 1;
        end
        for (int j = 0; j < nbytes; j++) begin
            drive_byte(pkt[j], j == 0, pass && j >= 4, pass && matched && j == 187, idx);
            if (gaps) tick_idle();
        end
        tick_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_en[i] = 0; m_pid[i] = 0; m_base[i] = 0; m_num[i] = 0; end
        for (int i = 0; i < 80; i++) begin m_val[i] = 0; m_msk[i] = 0; end
        m_wide = 0;
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_addr = 0; cfg_wdata = 0;
        in_valid = 0; in_start = 0; in_data = 0;
        exp_valid = 0; exp_match = 0; exp_data = 0; exp_idx = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        req = "R1 reset state";
        repeat (3) tick_idle();

        req = "R6 config";
        cfg(2'd0, 7'd0,  32'h8000_0000 | (2 << 20) | (0 << 13) | 32'h100);
        cfg(2'd0, 7'd7,  32'h8000_0000 | (1 << 20) | (3 << 13) | 32'h100);
        cfg(2'd0, 7'd3,  32'h8000_0000 | (0 << 20) | (5 << 13) | 32'hABC);
        cfg(2'd0, 7'd5,  32'h0000_0200);
        cfg(2'd0, 7'd31, 32'h8000_0000 | (1 << 20) | (2 << 13) | 32'h1234);
        cfg(2'd1, 7'd0, 32'h1122_3344); cfg(2'd2, 7'd0, 32'hFFFF_FFFF);
        cfg(2'd1, 7'd1, 32'hAB00_0000); cfg(2'd2, 7'd1, 32'hFF00_0000);
        cfg(2'd1, 7'd2, 32'h0000_0F00); cfg(2'd2, 7'd2, 32'h0000_0F00);
        cfg(2'd1, 7'd3, 32'h0000_0000); cfg(2'd2, 7'd3, 32'h0000_0000);
        tick_idle();

        req = "R6 exact 4-byte match, R5 payload";
        build(13'h100, 0, 32'h1122_3344, 32'h0, 1); send(188, 0);
        req = "R8 second condition of run";
        build(13'h100, 0, 32'hAB5A_5A5A, 32'h0, 2); send(188, 0);
        req = "R6 one masked bit differs, R9 no pulse";
        build(13'h100, 0, 32'h1122_3345, 32'h0, 3); send(188, 0);
        req = "R8 zero-count entry passes";
        build(13'hABC, 0, 32'h0, 32'h0, 4); send(188, 0);
        req = "R3 disabled entry";
        build(13'h200, 0, 32'h0, 32'h0, 5); send(188, 0);
        req = "R3 unknown PID";
        build(13'h0777, 0, 32'h0, 32'h0, 6); send(188, 0);
        req = "R3 entry 31 index";
        build(13'h1234, 0, 32'h1234_5F78, 32'h0, 7); send(188, 0);
        req = "R4 transport error dropped";
        build(13'h100, 1, 32'h1122_3344, 32'h0, 8); send(188, 0);
        req = "R2 bad sync ignored";
        build(13'h100, 0, 32'h1122_3344, 32'h0, 9); pkt[0] = 8'h46; send(188, 0);
        req = "R10 gaps between bytes";
        build(13'h100, 0, 32'hAB01_0203, 32'h0, 10); send(188, 1);
        req = "R11 restart mid-packet";
        build(13'h100, 0, 32'h1122_3344, 32'h0, 11); send(60, 0);
        build(13'h100, 0, 32'hAB00_0000, 32'h0, 12); send(188, 0);

        req = "R7 config";
        cfg(2'd3, 7'd0, 32'h1);
        cfg(2'd0, 7'd1, 32'h8000_0000 | (1 << 20) | (1 << 13) | 32'h055);
        cfg(2'd1, 7'd2, 32'hCAFE_0000); cfg(2'd2, 7'd2, 32'hFFFF_0000);
        cfg(2'd1, 7'd3, 32'h0000_00EE); cfg(2'd2, 7'd3, 32'h0000_00FF);
        tick_idle();
        req = "R7 8-byte match";
        build(13'h055, 0, 32'hCAFE_1234, 32'h9999_99EE, 13); send(188, 0);
        req = "R7 second half mismatch";
        build(13'h055, 0, 32'hCAFE_1234, 32'h9999_99EF, 14); send(188, 0);
        req = "R7 paired slots, R8 run of two";
        build(13'h100, 0, 32'h1122_3344, 32'hAB00_0000, 15); send(188, 0);
        build(13'h100, 0, 32'h1122_3344, 32'hAC00_0000, 16); send(188, 0);

        req = "R9 idle tail";
        repeat (4) tick_idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule